// File: doc/BRIEF.md
# Atomic 16-bit Register Access Bridge

This block joins an 8-bit peripheral bus to four 16-bit timer registers: a running count, two compare values and a capture value. The bus can move only one byte per access. The block still gives software whole-word reads and writes, and it does this with a single holding byte that all four registers share.

On the read side, software reads the low byte first. That access returns the live low byte. In the same cycle, the block parks the matching high byte in the holding byte. A later read of any high-byte address returns the parked byte, so the two halves always come from the same instant.

On the write side, software writes the high byte first, and that access only fills the holding byte. The low-byte write then loads both halves into the target register in one clock, together with a one-cycle commit strobe. The count register also advances on an external increment input. The capture register is loaded from the count on an external capture input.

Top module: `bridge16_access`

## Requirements
- R1: After reset, all four registers read 0, the holding byte is 0 and `commit_o` is 0.
- R2: The bus address is {register select, byte select}. Select 0 is the count, 1 is compare A, 2 is compare B and 3 is capture. Byte select 0 is the low byte and 1 is the high byte. A low-byte read returns the live low byte in the same cycle. At the next clock edge it copies that register's high byte into the holding byte.
- R3: A high-byte read returns the holding byte, whatever the live high byte of the addressed register is.
- R4: A high-byte write to a writable register loads only the holding byte. No register changes and no commit strobe fires.
- R5: A low-byte write loads {holding byte, written byte} into the addressed register at the next edge. It pulses that register's `commit_o` bit (bit index = select) for exactly the one cycle after that edge.
- R6: The holding byte is shared. A high-byte write to one register, followed by a high-byte write to another, makes the next low-byte write commit the second high byte.
- R7: The capture register is read-only. Writes to either of its addresses leave every register and the holding byte unchanged and fire no commit strobe.
- R8: With `cnt_inc` high, the count increases by one at each edge. In a cycle where a low-byte write commits to the count, the written value wins over the increment.
- R9: A `cap_load` pulse copies the count as it was before that edge into the capture register.
- R10: A write and a read in the same cycle act as the write alone: the read neither changes the holding byte nor drives data. `bus_rdata` is 0 in every cycle without an active read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | {register select, byte select} |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the same cycle as the read |
| cnt_inc | input | 1 | Advance the count by one |
| cap_load | input | 1 | Copy the count into the capture register |
| count_o | output | 16 | Count register |
| cmpa_o | output | 16 | Compare A register |
| cmpb_o | output | 16 | Compare B register |
| capt_o | output | 16 | Capture register |
| commit_o | output | 4 | One-cycle commit strobe per register |

## Verification
The assertions assume that `bus_addr`, `bus_wdata`, the strobes and the timer inputs are settled at each rising edge. They also assume that a commit check on compare A or compare B is not disturbed by `cap_load`, which never touches those registers. The checks that concern the count and capture registers are written with the increment and capture inputs in their antecedents, so that concurrent timer activity does not break them. The directed stimulus changes every input only on falling edges. It keeps `cnt_inc` low except in the test that targets the count, so expected values stay fixed between bus accesses.

// File: rtl/bridge16_pkg.sv
package bridge16_pkg;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int REG_COUNT = 0;
    localparam int REG_CMPA  = 1;
    localparam int REG_CMPB  = 2;
    localparam int REG_CAPT  = 3;
    // registers that software may write; capture is read-only
    localparam logic [NUM_REGS-1:0] WRITABLE = 4'b0111;
endpackage

// File: rtl/bridge16_decode.sv
module bridge16_decode
    import bridge16_pkg::*;
#(
    parameter int ADDR_W = SEL_W + 1
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    output logic [NUM_REGS-1:0] sel_oh,
    output logic                is_high,
    output logic                rd_act,
    output logic                wr_act
);
    logic [SEL_W-1:0] sel;
    assign sel     = bus_addr[ADDR_W-1:1];
    assign is_high = bus_addr[0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel_oh[g] = (sel == SEL_W'(g));
    end

    always_comb begin
        // a write takes the cycle; a concurrent read is dropped
        rd_act = bus_rd && !bus_wr;
        wr_act = bus_wr && ((sel_oh & WRITABLE) != '0);
    end
endmodule

// File: rtl/bridge16_temp.sv
module bridge16_temp #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              load_rd,
    input  logic [BYTE_W-1:0] live_high,
    output logic [BYTE_W-1:0] temp_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] temp;
    } temp_state_t;

    temp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_wr) begin
            st_d.temp = wdata;
        end else if (load_rd) begin
            st_d.temp = live_high;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign temp_o = st_q.temp;
endmodule

// File: rtl/bridge16_regfile.sv
module bridge16_regfile
    import bridge16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              commit_sel,
    input  logic [BYTE_W-1:0]                temp,
    input  logic [BYTE_W-1:0]                wdata,
    input  logic                             cnt_inc,
    input  logic                             cap_load,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o,
    output logic [NUM_REGS-1:0]              commit_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
        logic [NUM_REGS-1:0]             commit;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.commit = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (commit_sel[k]) begin
                // bus commit has priority over timer-side updates
                st_d.regs[k]   = {temp, wdata};
                st_d.commit[k] = 1'b1;
            end else if (k == REG_COUNT && cnt_inc) begin
                st_d.regs[k] = st_q.regs[k] + WORD_W'(1);
            end else if (k == REG_CAPT && cap_load) begin
                st_d.regs[k] = st_q.regs[REG_COUNT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o   = st_q.regs;
    assign commit_o = st_q.commit;
endmodule

// File: rtl/bridge16_access.sv
module bridge16_access
    import bridge16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int ADDR_W = SEL_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                cnt_inc,
    input  logic                cap_load,
    output logic [WORD_W-1:0]   count_o,
    output logic [WORD_W-1:0]   cmpa_o,
    output logic [WORD_W-1:0]   cmpb_o,
    output logic [WORD_W-1:0]   capt_o,
    output logic [NUM_REGS-1:0] commit_o
);
    logic [NUM_REGS-1:0]             sel_oh;
    logic                            is_high;
    logic                            rd_act;
    logic                            wr_act;
    logic [NUM_REGS-1:0]             commit_sel;
    logic [BYTE_W-1:0]               temp_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    logic [WORD_W-1:0]               sel_word;

    bridge16_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .sel_oh   (sel_oh),
        .is_high  (is_high),
        .rd_act   (rd_act),
        .wr_act   (wr_act)
    );

    assign commit_sel = (wr_act && !is_high) ? sel_oh : '0;

    // word of the addressed register
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            sel_word |= sel_oh[k] ? regs[k] : '0;
        end
    end

    bridge16_temp #(.BYTE_W(BYTE_W)) u_temp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_wr   (wr_act && is_high),
        .wdata     (bus_wdata),
        .load_rd   (rd_act && !is_high),
        .live_high (sel_word[WORD_W-1:BYTE_W]),
        .temp_o    (temp_q)
    );

    bridge16_regfile #(.BYTE_W(BYTE_W)) u_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_sel (commit_sel),
        .temp       (temp_q),
        .wdata      (bus_wdata),
        .cnt_inc    (cnt_inc),
        .cap_load   (cap_load),
        .regs_o     (regs),
        .commit_o   (commit_o)
    );

    always_comb begin
        if (!rd_act) begin
            bus_rdata = '0;
        end else if (is_high) begin
            bus_rdata = temp_q;
        end else begin
            bus_rdata = sel_word[BYTE_W-1:0];
        end
    end

    assign count_o = regs[REG_COUNT];
    assign cmpa_o  = regs[REG_CMPA];
    assign cmpb_o  = regs[REG_CMPB];
    assign capt_o  = regs[REG_CAPT];
endmodule

// File: rtl/bridge16_checker.sv
module bridge16_checker
    import bridge16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int ADDR_W = SEL_W + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [BYTE_W-1:0]   bus_rdata,
    input logic                cnt_inc,
    input logic                cap_load,
    input logic [WORD_W-1:0]   count_o,
    input logic [WORD_W-1:0]   cmpa_o,
    input logic [WORD_W-1:0]   cmpb_o,
    input logic [WORD_W-1:0]   capt_o,
    input logic [NUM_REGS-1:0] commit_o,
    input logic [BYTE_W-1:0]   temp_q
);
    localparam logic [ADDR_W-1:0] A_CNT_L = {SEL_W'(REG_COUNT), 1'b0};
    localparam logic [ADDR_W-1:0] A_CA_L  = {SEL_W'(REG_CMPA), 1'b0};
    localparam logic [SEL_W-1:0]  S_CAPT  = SEL_W'(REG_CAPT);

    assert_low_read_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_CNT_L) |=> temp_q == $past(count_o[WORD_W-1:BYTE_W]));

    assert_high_read_temp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[0]) |-> bus_rdata == temp_q);

    assert_high_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |=> ($stable(cmpa_o) && $stable(cmpb_o) && commit_o == '0));

    assert_low_write_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CA_L) |=> (cmpa_o == {$past(temp_q), $past(bus_wdata)} && commit_o == 4'b0010));

    assert_commit_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_o));

    assert_capture_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1:1] == S_CAPT && !cap_load) |=> ($stable(temp_q) && $stable(capt_o) && commit_o == '0));

    assert_write_beats_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_L && cnt_inc) |=> count_o[BYTE_W-1:0] == $past(bus_wdata));

    assert_capture_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> capt_o == $past(count_o));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |-> bus_rdata == '0);
endmodule

bind bridge16_access bridge16_checker #(.BYTE_W(BYTE_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_inc   (cnt_inc),
    .cap_load  (cap_load),
    .count_o   (count_o),
    .cmpa_o    (cmpa_o),
    .cmpb_o    (cmpb_o),
    .capt_o    (capt_o),
    .commit_o  (commit_o),
    .temp_q    (temp_q)
);

// File: tb/test_bridge16_access.sv
`timescale 1ns/1ps
module test_bridge16_access;
    localparam logic [2:0] A_CNT_L = 3'b000, A_CNT_H = 3'b001;
    localparam logic [2:0] A_CA_L  = 3'b010, A_CA_H  = 3'b011;
    localparam logic [2:0] A_CB_L  = 3'b100, A_CB_H  = 3'b101;
    localparam logic [2:0] A_CP_L  = 3'b110, A_CP_H  = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cnt_inc = 1'b0, cap_load = 1'b0;
    logic [15:0] count_o, cmpa_o, cmpb_o, capt_o;
    logic [3:0]  commit_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bridge16_access i_bridge16_access (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_inc(cnt_inc), .cap_load(cap_load), .count_o(count_o),
        .cmpa_o(cmpa_o), .cmpb_o(cmpb_o), .capt_o(capt_o), .commit_o(commit_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // returns data seen during the read cycle
    task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 count", count_o, 16'h0);
        chk("R1 cmpa", cmpa_o, 16'h0);
        chk("R1 cmpb", cmpb_o, 16'h0);
        chk("R1 capt", capt_o, 16'h0);
        chk("R1 commit", {12'h0, commit_o}, 16'h0);
        rd_byte(A_CB_H, d);
        chk("R1 holding byte", {8'h0, d}, 16'h0);
    endtask

    task automatic t_word_write();
        wr_byte(A_CA_H, 8'h12);
        chk("R4 high write leaves cmpa", cmpa_o, 16'h0);
        chk("R4 no commit", {12'h0, commit_o}, 16'h0);
        wr_byte(A_CA_L, 8'h34);
        chk("R5 cmpa committed", cmpa_o, 16'h1234);
        chk("R5 commit strobe", {12'h0, commit_o}, 16'h0002);
        @(negedge clk);
        chk("R5 strobe one cycle", {12'h0, commit_o}, 16'h0);
    endtask

    task automatic t_word_read();
        logic [7:0] d;
        wr_byte(A_CB_H, 8'hAB);
        wr_byte(A_CB_L, 8'hCD);
        chk("R5 cmpb committed", cmpb_o, 16'hABCD);
        rd_byte(A_CA_L, d);
        chk("R2 live low byte", {8'h0, d}, 16'h0034);
        rd_byte(A_CB_H, d);
        chk("R3 high read returns holding byte", {8'h0, d}, 16'h0012);
    endtask

    task automatic t_shared_latch();
        wr_byte(A_CA_H, 8'h11);
        wr_byte(A_CB_H, 8'h22);
        wr_byte(A_CA_L, 8'h33);
        chk("R6 interleaved high byte", cmpa_o, 16'h2233);
        chk("R6 cmpb untouched", cmpb_o, 16'hABCD);
    endtask

    task automatic t_capture_ro();
        logic [7:0] d;
        wr_byte(A_CB_H, 8'h55);
        wr_byte(A_CP_H, 8'h99);
        chk("R7 no strobe on capture high", {12'h0, commit_o}, 16'h0);
        wr_byte(A_CP_L, 8'h66);
        chk("R7 capt unchanged", capt_o, 16'h0);
        chk("R7 no strobe on capture low", {12'h0, commit_o}, 16'h0);
        rd_byte(A_CA_H, d);
        chk("R7 holding byte kept", {8'h0, d}, 16'h0055);
    endtask

    task automatic t_count_priority();
        wr_byte(A_CNT_H, 8'h12);
        @(negedge clk);
        cnt_inc = 1'b1; bus_wr = 1'b1; bus_addr = A_CNT_L; bus_wdata = 8'h34;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 write wins over increment", count_o, 16'h1234);
        chk("R8 count strobe", {12'h0, commit_o}, 16'h0001);
        @(negedge clk);
        @(negedge clk);
        cnt_inc = 1'b0;
        chk("R8 increments", count_o, 16'h1236);
    endtask

    task automatic t_capture_load();
        logic [7:0] d;
        @(negedge clk);
        cap_load = 1'b1;
        @(negedge clk);
        cap_load = 1'b0;
        chk("R9 capture copy", capt_o, 16'h1236);
        rd_byte(A_CP_L, d);
        chk("R9 capture low", {8'h0, d}, 16'h0036);
        rd_byte(A_CP_H, d);
        chk("R9 capture high via R2 park", {8'h0, d}, 16'h0012);
    endtask

    task automatic t_rd_wr_conflict();
        logic [7:0] d;
        wr_byte(A_CB_H, 8'h77);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = A_CA_L; bus_wdata = 8'h01;
        #1 d = bus_rdata;
        chk("R10 rdata zero during write", {8'h0, d}, 16'h0);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #1 chk("R10 rdata zero when idle", {8'h0, bus_rdata}, 16'h0);
        chk("R10 write performed", cmpa_o, 16'h7701);
        rd_byte(A_CB_H, d);
        chk("R10 read did not park", {8'h0, d}, 16'h0077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_write();
        t_word_read();
        t_shared_latch();
        t_capture_ro();
        t_count_priority();
        t_capture_load();
        t_rd_wr_conflict();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule